// File: doc/BRIEF.md
# Power-On Strap Capture Sequencer

This block decides, once per power cycle, how a clock generator's five shared configuration pins are used. After the power-good input goes high, the pins are kept in high impedance for a fixed number of reference-clock cycles. During that window, external pull resistors set the pin levels. The levels are passed through two-flop synchronizers. On the last cycle of the window they are latched as four frequency-select bits and one mode bit. After that, every shared pin's output driver is enabled and the clock outputs are allowed to toggle.

The latched mode bit also sets the role of a sixth pin:

- When the mode bit is 1, that pin becomes a reference clock output.
- When the mode bit is 0, it stays an input. It carries an active-low request to stop the processor clocks. That request is synchronized and presented on `stop_req`.

Power-good is the only reset. No logic reset can restart the capture, so the latched configuration holds until power is removed and restored.

Top module: `strap_capture`

## Requirements
- R1: While `pwr_good` is low, all of the following hold: `strap_pad_oe` is 0, `strap_done` is 0, `clk_run` is 0, `fsel` is 0, `mode_sel` is 0, `pin2_oe` is 0 and `stop_req` is 0.
- R2: During the capture window, `strap_pad_oe` stays 0 and `clk_run` stays 0, so the shared pins are high impedance and the clock outputs are held low. The window is the first `WIN_CYC` - 1 rising edges of `clk_ref` after `pwr_good` goes high.
- R3: `strap_done` first becomes 1 right after the `WIN_CYC`-th rising edge following `pwr_good` going high.
- R4: The latched values take the levels of the shared pins, provided those levels were held for at least two edges before the end of the window. The bit map is: `strap_pad_i[3:0]` goes to `fsel[3:0]`, and `strap_pad_i[4]` goes to `mode_sel`.
- R5: Once `strap_done` is 1, all five bits of `strap_pad_oe` are 1 and `clk_run` is 1.
- R6: After `strap_done` is set, changes on `strap_pad_i` have no effect on `fsel` or `mode_sel`.
- R7: `strap_done` and the latched values persist until `pwr_good` drops. A new rise of `pwr_good` starts a fresh window and captures the pin levels again.
- R8: With `mode_sel` = 1 after capture, `pin2_oe` is 1 and `stop_req` stays 0 whatever the level of `pin2_i`.
- R9: With `mode_sel` = 0 after capture, `pin2_oe` is 0. `stop_req` equals the inverse of `pin2_i`, as seen through a two-flop synchronizer, so it lags `pin2_i` by two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock that times the window |
| pwr_good | input | 1 | Supply-valid indication; low acts as an asynchronous reset |
| strap_pad_i | input | 5 | Levels on the shared pins: [3:0] frequency selects, [4] mode |
| pin2_i | input | 1 | Level on the dual-role pin when it is used as an input (low requests a stop) |
| strap_pad_oe | output | 5 | Output enables for the shared pins; 0 means high impedance |
| fsel | output | 4 | Latched frequency-select bits |
| mode_sel | output | 1 | Latched mode bit |
| strap_done | output | 1 | Capture complete |
| clk_run | output | 1 | Clock outputs may toggle; when 0 they are held low |
| pin2_oe | output | 1 | Output enable for the dual-role pin when it acts as a reference output |
| stop_req | output | 1 | Synchronized active-high stop request from the dual-role pin |

## Verification
The hardest situation to reach is a second capture within one run. Being restartable only by power means the stimulus has to drop `pwr_good` in the middle of normal operation. It must also check that everything returns to its reset values while power-good is low, and then raise power-good again with a different set of pin levels. The new values must be latched, not the old ones. Checking that the window ends on the exact edge needs the same care. The bench releases `pwr_good` between clock edges and counts edges from there, so it can see `strap_done` rise on the `WIN_CYC`-th edge and not one edge earlier or later. The stop-request path is reached only after a capture with the mode strap low, so a separate power cycle is used for it.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int unsigned NUM_FS    = 4;
    localparam int unsigned NUM_STRAP = NUM_FS + 1;
    localparam int unsigned MODE_BIT  = NUM_FS;

    typedef enum logic {
        PH_WINDOW = 1'b0,
        PH_RUN    = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [NUM_FS-1:0]   fs;
        logic                mode;
    } seq_state_t;

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int unsigned WIDTH   = 1,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    // one two-stage chain per bit
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [1:0] stage_d, stage_q;

        always_comb begin
            stage_d = {stage_q[0], async_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= {2{RST_VAL}};
            else        stage_q <= stage_d;
        end

        assign sync_o[g] = stage_q[1];
    end

endmodule

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
    parameter int unsigned WIN_CYC = 28636
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic last_o
);

    localparam int unsigned CW = $clog2(WIN_CYC + 1);
    localparam logic [CW-1:0] LAST_VAL = CW'(WIN_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (run_i && (cnt_q != LAST_VAL)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = run_i && (cnt_q == LAST_VAL);

endmodule

// File: rtl/strap_pin_ctrl.sv
module strap_pin_ctrl #(
    parameter int unsigned NUM_PADS = 5
) (
    input  logic                done_i,
    input  logic                mode_i,
    input  logic                pin2_sync_i,
    output logic [NUM_PADS-1:0] pad_oe_o,
    output logic                clk_run_o,
    output logic                pin2_oe_o,
    output logic                stop_req_o
);

    for (genvar g = 0; g < NUM_PADS; g++) begin : g_oe
        assign pad_oe_o[g] = done_i;
    end

    always_comb begin
        clk_run_o  = done_i;
        pin2_oe_o  = done_i &  mode_i;
        stop_req_o = done_i & ~mode_i & ~pin2_sync_i;
    end

endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import strap_pkg::*;
#(
    parameter int unsigned WIN_CYC = 28636
) (
    input  logic                 clk_ref,
    input  logic                 pwr_good,
    input  logic [NUM_STRAP-1:0] strap_pad_i,
    input  logic                 pin2_i,
    output logic [NUM_STRAP-1:0] strap_pad_oe,
    output logic [NUM_FS-1:0]    fsel,
    output logic                 mode_sel,
    output logic                 strap_done,
    output logic                 clk_run,
    output logic                 pin2_oe,
    output logic                 stop_req
);

    seq_state_t           st_d, st_q;
    logic [NUM_STRAP-1:0] pad_sync;
    logic                 pin2_sync;
    logic                 win_last;

    strap_sync #(.WIDTH(NUM_STRAP), .RST_VAL(1'b0)) i_pad_sync (
        .clk     (clk_ref),
        .rst_n   (pwr_good),
        .async_i (strap_pad_i),
        .sync_o  (pad_sync)
    );

    strap_sync #(.WIDTH(1), .RST_VAL(1'b1)) i_pin2_sync (
        .clk     (clk_ref),
        .rst_n   (pwr_good),
        .async_i (pin2_i),
        .sync_o  (pin2_sync)
    );

    strap_window_timer #(.WIN_CYC(WIN_CYC)) i_timer (
        .clk    (clk_ref),
        .rst_n  (pwr_good),
        .run_i  (st_q.phase == PH_WINDOW),
        .last_o (win_last)
    );

    always_comb begin
        st_d = st_q;
        if (win_last) begin
            st_d.phase = PH_RUN;
            st_d.fs    = pad_sync[NUM_FS-1:0];
            st_d.mode  = pad_sync[MODE_BIT];
        end
    end

    always_ff @(posedge clk_ref or negedge pwr_good) begin
        if (!pwr_good) st_q <= '{phase: PH_WINDOW, fs: '0, mode: 1'b0};
        else           st_q <= st_d;
    end

    assign strap_done = (st_q.phase == PH_RUN);
    assign fsel       = st_q.fs;
    assign mode_sel   = st_q.mode;

    strap_pin_ctrl #(.NUM_PADS(NUM_STRAP)) i_pin_ctrl (
        .done_i      (strap_done),
        .mode_i      (st_q.mode),
        .pin2_sync_i (pin2_sync),
        .pad_oe_o    (strap_pad_oe),
        .clk_run_o   (clk_run),
        .pin2_oe_o   (pin2_oe),
        .stop_req_o  (stop_req)
    );

endmodule

// File: rtl/strap_capture_chk.sv
module strap_capture_chk #(
    parameter int unsigned WIN_CYC = 28636
) (
    input logic       clk_ref,
    input logic       pwr_good,
    input logic [4:0] strap_pad_oe,
    input logic [3:0] fsel,
    input logic       mode_sel,
    input logic       strap_done,
    input logic       clk_run,
    input logic       pin2_oe,
    input logic       stop_req
);

    localparam int unsigned CW = $clog2(WIN_CYC + 2);

    logic [CW-1:0] edges_q;

    always_ff @(posedge clk_ref or negedge pwr_good) begin
        if (!pwr_good)                    edges_q <= '0;
        else if (edges_q != CW'(WIN_CYC)) edges_q <= edges_q + 1'b1;
    end

    // R2
    pads_hiz_chk: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        !strap_done |-> (strap_pad_oe == 5'b0) && !clk_run);

    // R3
    window_len_chk: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        $rose(strap_done) |-> (edges_q == CW'(WIN_CYC)));

    // R5
    pads_on_chk: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        strap_done |-> (strap_pad_oe == 5'h1f) && clk_run);

    // R6
    latch_hold_chk: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        (strap_done && $past(strap_done)) |-> ($stable(fsel) && $stable(mode_sel)));

    // R7
    done_sticky_chk: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        $past(strap_done) |-> strap_done);

    // R8
    pin2_role_chk: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        pin2_oe |-> (mode_sel && strap_done && !stop_req));

    // R9
    stop_role_chk: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        stop_req |-> (!mode_sel && strap_done && !pin2_oe));

endmodule

bind strap_capture strap_capture_chk #(.WIN_CYC(WIN_CYC)) i_strap_capture_chk (
    .clk_ref      (clk_ref),
    .pwr_good     (pwr_good),
    .strap_pad_oe (strap_pad_oe),
    .fsel         (fsel),
    .mode_sel     (mode_sel),
    .strap_done   (strap_done),
    .clk_run      (clk_run),
    .pin2_oe      (pin2_oe),
    .stop_req     (stop_req)
);

// File: tb/test_strap_capture.sv
module test_strap_capture;

    localparam int unsigned WIN = 48;

    logic       clk_ref = 1'b0;
    logic       pwr_good = 1'b0;
    logic [4:0] strap_pad_i = 5'b0;
    logic       pin2_i = 1'b1;
    logic [4:0] strap_pad_oe;
    logic [3:0] fsel;
    logic       mode_sel, strap_done, clk_run, pin2_oe, stop_req;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk_ref = ~clk_ref;

    strap_capture #(.WIN_CYC(WIN)) i_strap_capture (
        .clk_ref, .pwr_good, .strap_pad_i, .pin2_i, .strap_pad_oe, .fsel,
        .mode_sel, .strap_done, .clk_run, .pin2_oe, .stop_req
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int outs();
        return {strap_pad_oe, fsel, mode_sel, strap_done, clk_run, pin2_oe, stop_req};
    endfunction

    // raise power with given straps, check window edge by edge, end right after done
    task automatic power_up(input logic [4:0] straps);
        bit quiet = 1'b1;
        int bad = 0;
        strap_pad_i = straps;
        @(negedge clk_ref);
        pwr_good = 1'b1;
        for (int i = 1; i < WIN; i++) begin
            @(negedge clk_ref);
            if (strap_done || clk_run || (strap_pad_oe != 5'b0)) begin
                quiet = 1'b0;
                bad = outs();
            end
        end
        chk(quiet, "R2 window held quiet", bad, 0);
        @(negedge clk_ref);
        chk(strap_done == 1'b1, "R3 done after WIN edges", strap_done, 1);
    endtask

    task automatic t_reset();
        pwr_good = 1'b0;
        repeat (3) @(negedge clk_ref);
        chk(outs() == 0, "R1 reset outputs", outs(), 0);
    endtask

    task automatic t_capture(input logic [4:0] straps);
        power_up(straps);
        chk(fsel == straps[3:0], "R4 fsel latched", fsel, straps[3:0]);
        chk(mode_sel == straps[4], "R4 mode latched", mode_sel, straps[4]);
        chk(strap_pad_oe == 5'h1f && clk_run, "R5 outputs enabled",
            {strap_pad_oe, clk_run}, 6'h3f);
    endtask

    task automatic t_ignore();
        logic [3:0] f0 = fsel;
        logic       m0 = mode_sel;
        strap_pad_i = ~strap_pad_i;
        repeat (5) @(negedge clk_ref);
        chk(fsel == f0 && mode_sel == m0, "R6 later pad changes ignored",
            {fsel, mode_sel}, {f0, m0});
        chk(strap_done == 1'b1, "R7 done persists", strap_done, 1);
    endtask

    task automatic t_mode1();
        pin2_i = 1'b0;
        repeat (3) @(negedge clk_ref);
        chk(pin2_oe == 1'b1 && stop_req == 1'b0, "R8 pin2 output, stop low",
            {pin2_oe, stop_req}, 2'b10);
        pin2_i = 1'b1;
        repeat (3) @(negedge clk_ref);
        chk(pin2_oe == 1'b1 && stop_req == 1'b0, "R8 pin2 output held",
            {pin2_oe, stop_req}, 2'b10);
    endtask

    task automatic t_mode0();
        chk(pin2_oe == 1'b0 && stop_req == 1'b0, "R9 pin2 input idle",
            {pin2_oe, stop_req}, 2'b00);
        pin2_i = 1'b0;
        @(negedge clk_ref);
        chk(stop_req == 1'b0, "R9 stop one edge early", stop_req, 0);
        @(negedge clk_ref);
        chk(stop_req == 1'b1, "R9 stop after two edges", stop_req, 1);
        pin2_i = 1'b1;
        repeat (2) @(negedge clk_ref);
        chk(stop_req == 1'b0, "R9 stop released", stop_req, 0);
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_capture(5'b1_0110);
        t_ignore();
        t_mode1();
        // R7: dropping power clears, next power-up relatches new straps
        @(negedge clk_ref);
        pwr_good = 1'b0;
        #1;
        chk(outs() == 0, "R1 R7 cleared on power loss", outs(), 0);
        t_reset();
        t_capture(5'b0_1001);
        t_mode0();
        t_ignore();
        t_reset();
        t_capture(5'b0_0000);
        t_capture_more();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic t_capture_more();
        t_reset();
        t_capture(5'b1_1111);
        t_mode1();
    endtask

endmodule